// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit is the flag and interrupt section of a word-wide SPI controller. The transmit and receive FIFOs sit outside it and report their fill levels as occupancy counts. From these counts the unit builds the level flags (transmit empty and full, receive ready and full) anew in every cycle. It also keeps two sticky event flags: receive overflow and transfer complete. Software clears the sticky flags by writing ones to the status register. One interrupt line is driven from the status bits, masked by an interrupt-enable register.

Received words come in on a valid strobe with no back-pressure. When the receive FIFO has room, the word goes on to the storage through a push strobe. When the FIFO is full, the word is dropped and the overflow flag is set. The unit also decides what a read of the receive data register returns. It issues the pop strobe to the receive FIFO only when a real word is handed out.

Register indices (word addresses): 0 receive data, 1 transmit data, 2 interrupt enable, 3 status. Status bits: 0 transmit empty, 1 transmit threshold, 2 transmit full, 3 receive ready, 4 receive threshold, 5 receive full, 6 receive overflow, 7 transfer complete. Read data is registered and appears in the cycle after the read strobe.

Top module: `spi_stat_irq_unit`

## Requirements
- R1: After reset with both occupancy counts at zero, the status register reads 0x00000003 and `irq` is low.
- R2: Status bit 0 is 1 exactly when `tx_count` is 0. Bit 2 is 1 exactly when `tx_count` equals the FIFO depth (default 64).
- R3: Status bit 3 is 1 exactly when `rx_count` is nonzero. Bit 5 is 1 exactly when `rx_count` equals the FIFO depth.
- R4: Status bit 1 always reads 1 and bit 4 always reads 0. Bits 31:8 read 0.
- R5: A received word (`rx_word_vld`) that arrives while the receive FIFO is full raises no `rx_push` and sets status bit 6 from the next cycle on. A received word that arrives with room raises `rx_push` in the same cycle and leaves bit 6 unchanged.
- R6: A `xfer_done` pulse sets status bit 7 from the next cycle on. Bit 7 stays set until it is cleared.
- R7: Writing 1 to status bit 6 or bit 7 clears that bit. Writes to any other status bit have no effect. When a set event and a clear fall in the same cycle, the set wins.
- R8: `irq` is high in the same cycle whenever the AND of the status bits and the interrupt-enable bits is nonzero.
- R9: While `ctrl_en` is low, a read of the receive data register returns 0 and raises no `rx_pop`.
- R10: While `ctrl_en` is high and `rx_count` is 0, a read of the receive data register returns 0xDEADBEEF and raises no `rx_pop`.
- R11: While `ctrl_en` is high and `rx_count` is nonzero, a read of the receive data register raises `rx_pop` for that cycle and returns `rx_head`.
- R12: A read of the transmit data register returns 0. A write to the receive data register pops nothing and changes no status bit.
- R13: The interrupt-enable register holds bits 7:0 of the written value and reads back with bits 31:8 at 0. It resets to 0. Unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_word_vld | input | 1 | Received word arriving from the serial engine |
| rx_push | output | 1 | Store the arriving word in the receive FIFO |
| rx_head | input | DATA_W | Oldest word in the receive FIFO |
| rx_pop | output | 1 | Remove the oldest receive word |
| xfer_done | input | 1 | Transfer-complete pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every cycle, that a word arriving at a full FIFO always leads to the overflow flag and never to a push. It also watches that a word with room is always pushed, and that no pop occurs while the FIFO is empty or the unit is disabled. It further checks that the transfer-complete flag follows its pulse and holds until cleared, that only the two sticky bits are ever cleared, and that the interrupt line stays low with nothing enabled. The directed scenarios are needed for the things a property cannot see. These are the exact read values: the empty marker, zero while disabled, the head word, and the status encodings at each fill level. They also cover a set that collides with a clear, register readback, and the fact that writes to the receive data register and to the level bits change nothing.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int ST_W    = 8;
  localparam int ST_TE   = 0;
  localparam int ST_TDR  = 1;
  localparam int ST_TF   = 2;
  localparam int ST_RR   = 3;
  localparam int ST_RDR  = 4;
  localparam int ST_RF   = 5;
  localparam int ST_RO   = 6;
  localparam int ST_TC   = 7;

  localparam int RIDX_RXD  = 0;
  localparam int RIDX_TXD  = 1;
  localparam int RIDX_IEN  = 2;
  localparam int RIDX_STAT = 3;

  localparam logic [ST_W-1:0] W1C_BITS = ST_W'((1 << ST_RO) | (1 << ST_TC));
  localparam logic [31:0]     RX_EMPTY_MARK = 32'hDEADBEEF;
endpackage

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_word_vld,
  input  logic             xfer_done,
  input  logic [ST_W-1:0]  clr_mask,
  output logic [ST_W-1:0]  status,
  output logic             rx_push,
  output logic             rx_empty
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(FIFO_DEPTH);

  logic tx_empty, tx_full, rx_full;
  logic ro_q, tc_q;

  assign tx_empty = (tx_count == '0);
  assign tx_full  = (tx_count == FULL_LVL);
  assign rx_empty = (rx_count == '0);
  assign rx_full  = (rx_count == FULL_LVL);

  // Arriving words are never back-pressured: accepted with room, else dropped.
  assign rx_push = rx_word_vld && !rx_full;

  // Sticky flags: a set event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ro_q <= 1'b0;
      tc_q <= 1'b0;
    end else begin
      if (rx_word_vld && rx_full) ro_q <= 1'b1;
      else if (clr_mask[ST_RO])   ro_q <= 1'b0;
      if (xfer_done)              tc_q <= 1'b1;
      else if (clr_mask[ST_TC])   tc_q <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_TE]   = tx_empty;
    status[ST_TDR]  = 1'b1;
    status[ST_TF]   = tx_full;
    status[ST_RR]   = !rx_empty;
    status[ST_RDR]  = 1'b0;
    status[ST_RF]   = rx_full;
    status[ST_RO]   = ro_q;
    status[ST_TC]   = tc_q;
  end
endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs
  import spi_stat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ST_W-1:0]   status,
  input  logic              rx_empty,
  input  logic [DATA_W-1:0] rx_head,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_pop,
  output logic [ST_W-1:0]   clr_mask,
  output logic [ST_W-1:0]   ien
);
  logic hit_rxd, hit_txd, hit_ien, hit_stat;
  logic [DATA_W-1:0] rd_next, rdata_q;
  logic [ST_W-1:0]   ien_q;
  logic              unused_wdata_hi;

  assign hit_rxd  = (reg_addr == ADDR_W'(RIDX_RXD));
  assign hit_txd  = (reg_addr == ADDR_W'(RIDX_TXD));
  assign hit_ien  = (reg_addr == ADDR_W'(RIDX_IEN));
  assign hit_stat = (reg_addr == ADDR_W'(RIDX_STAT));
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:ST_W];

  assign clr_mask = (reg_wr && hit_stat) ? (reg_wdata[ST_W-1:0] & W1C_BITS) : '0;
  assign rx_pop   = reg_rd && hit_rxd && ctrl_en && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ien_q <= '0;
    else if (reg_wr && hit_ien) ien_q <= reg_wdata[ST_W-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (hit_rxd) begin
      if (!ctrl_en)      rd_next = '0;
      else if (rx_empty) rd_next = DATA_W'(RX_EMPTY_MARK);
      else               rd_next = rx_head;
    end else if (hit_txd) begin
      rd_next = '0;
    end else if (hit_ien) begin
      rd_next = DATA_W'(ien_q);
    end else if (hit_stat) begin
      rd_next = DATA_W'(status);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_next;
  end

  assign reg_rdata = rdata_q;
  assign ien       = ien_q;
endmodule

// File: rtl/spi_stat_irq_unit.sv
module spi_stat_irq_unit
  import spi_stat_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_word_vld,
  output logic              rx_push,
  input  logic [DATA_W-1:0] rx_head,
  output logic              rx_pop,
  input  logic              xfer_done,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [ST_W-1:0] status_w, clr_w, ien_w;
  logic            rx_empty_w;

  spi_stat_flags #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .rx_word_vld(rx_word_vld), .xfer_done(xfer_done), .clr_mask(clr_w),
    .status(status_w), .rx_push(rx_push), .rx_empty(rx_empty_w)
  );

  spi_stat_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status(status_w), .rx_empty(rx_empty_w), .rx_head(rx_head),
    .reg_rdata(reg_rdata), .rx_pop(rx_pop), .clr_mask(clr_w), .ien(ien_w)
  );

  assign irq = |(status_w & ien_w);
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk
  import spi_stat_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_word_vld,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             xfer_done,
  input logic             irq,
  input logic [ST_W-1:0]  status,
  input logic [ST_W-1:0]  ien,
  input logic [ST_W-1:0]  clr_mask
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(FIFO_DEPTH);

  a_r5_drop_sets_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_vld && rx_count == FULL_LVL) |=> status[ST_RO]);
  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == FULL_LVL) |-> !rx_push);
  a_r5_push_with_room: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_vld && rx_count != FULL_LVL) |-> rx_push);
  a_r6_done_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[ST_TC]);
  a_r6_tc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_TC] && !clr_mask[ST_TC]) |=> status[ST_TC]);
  a_r7_only_sticky_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask & ~W1C_BITS) == '0);
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
  a_r8_tx_empty_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[ST_TE] && tx_count == '0) |-> irq);
  a_r9_no_pop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !rx_pop);
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !rx_pop);
endmodule

bind spi_stat_irq_unit spi_stat_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .tx_count(tx_count),
  .rx_count(rx_count), .rx_word_vld(rx_word_vld), .rx_push(rx_push),
  .rx_pop(rx_pop), .xfer_done(xfer_done), .irq(irq), .status(status_w),
  .ien(ien_w), .clr_mask(clr_w)
);

// File: tb/sim_spi_stat_irq_unit.sv
module sim_spi_stat_irq_unit;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int AW    = 3;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_en = 1'b0;
  logic [CW-1:0] tx_count = '0;
  logic [CW-1:0] rx_count = '0;
  logic          rx_word_vld = 1'b0;
  logic          rx_push;
  logic [DW-1:0] rx_head = '0;
  logic          rx_pop;
  logic          xfer_done = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_stat_irq_unit #(.FIFO_DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .tx_count(tx_count),
    .rx_count(rx_count), .rx_word_vld(rx_word_vld), .rx_push(rx_push),
    .rx_head(rx_head), .rx_pop(rx_pop), .xfer_done(xfer_done),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] data, output logic popped);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(idx);
    #1 popped = rx_pop;
    @(negedge clk);
    reg_rd = 1'b0;
    data = reg_rdata;
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(idx); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic p;
    rd_reg(3, d, p); check("R1 status after reset", d, 32'h3);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd_reg(2, d, p); check("R13 enable reset", d, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] d; logic p;
    tx_count = 5;  rd_reg(3, d, p); check("R2 tx partial", d, 32'h02);
    tx_count = CW'(DEPTH); rd_reg(3, d, p); check("R2 tx full", d, 32'h06);
    tx_count = 0; rx_count = 1; rd_reg(3, d, p); check("R3 rx ready", d, 32'h0B);
    rx_count = CW'(DEPTH); rd_reg(3, d, p); check("R3 R4 rx full", d, 32'h2B);
    wr_reg(3, 32'hFFFF_FF3F); rd_reg(3, d, p); check("R7 level bits unaffected", d, 32'h2B);
    rx_count = 0;
  endtask

  task automatic t_overflow();
    logic [31:0] d; logic p;
    rx_count = 10;
    @(negedge clk); rx_word_vld = 1'b1;
    #1 check("R5 push with room", {31'b0, rx_push}, 32'h1);
    @(negedge clk); rx_word_vld = 1'b0;
    rd_reg(3, d, p); check("R5 no overflow with room", d & 32'h40, 32'h0);
    rx_count = CW'(DEPTH);
    @(negedge clk); rx_word_vld = 1'b1;
    #1 check("R5 no push when full", {31'b0, rx_push}, 32'h0);
    @(negedge clk); rx_word_vld = 1'b0;
    rd_reg(3, d, p); check("R5 overflow sticky", d, 32'h6B);
    wr_reg(3, 32'h80); rd_reg(3, d, p); check("R7 clear TC leaves RO", d, 32'h6B);
    wr_reg(3, 32'h40); rd_reg(3, d, p); check("R7 clear RO", d, 32'h2B);
    rx_count = 0;
  endtask

  task automatic t_done();
    logic [31:0] d; logic p;
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    rd_reg(3, d, p); check("R6 tc set", d, 32'h83);
    rd_reg(3, d, p); check("R6 tc sticky", d, 32'h83);
    @(negedge clk); xfer_done = 1'b1; reg_wr = 1'b1; reg_addr = 3; reg_wdata = 32'h80;
    @(negedge clk); xfer_done = 1'b0; reg_wr = 1'b0;
    rd_reg(3, d, p); check("R7 set beats clear", d, 32'h83);
    wr_reg(3, 32'hC0); rd_reg(3, d, p); check("R7 tc cleared", d, 32'h03);
  endtask

  task automatic t_irq();
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    wr_reg(2, 32'h01);
    check("R8 irq on tx empty", {31'b0, irq}, 32'h1);
    @(negedge clk); tx_count = 3;
    #1 check("R8 irq drops with source", {31'b0, irq}, 32'h0);
    wr_reg(2, 32'h40);
    rx_count = CW'(DEPTH);
    @(negedge clk); rx_word_vld = 1'b1;
    @(negedge clk); rx_word_vld = 1'b0;
    check("R8 irq on overflow", {31'b0, irq}, 32'h1);
    wr_reg(3, 32'h40);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);
    wr_reg(2, 32'h0); tx_count = 0; rx_count = 0;
  endtask

  task automatic t_rxread();
    logic [31:0] d; logic p;
    ctrl_en = 1'b0; rx_count = 5; rx_head = 32'h1234_5678;
    rd_reg(0, d, p); check("R9 disabled read", d, 32'h0);
    check("R9 no pop disabled", {31'b0, p}, 32'h0);
    ctrl_en = 1'b1; rx_count = 0;
    rd_reg(0, d, p); check("R10 empty marker", d, 32'hDEADBEEF);
    check("R10 no pop empty", {31'b0, p}, 32'h0);
    rx_count = 5;
    rd_reg(0, d, p); check("R11 head word", d, 32'h1234_5678);
    check("R11 pop", {31'b0, p}, 32'h1);
  endtask

  task automatic t_misc();
    logic [31:0] d; logic p;
    rd_reg(1, d, p); check("R12 tx data reads zero", d, 32'h0);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 0; reg_wdata = 32'hFFFF_FFFF;
    #1 check("R12 rx write no pop", {31'b0, rx_pop}, 32'h0);
    @(negedge clk); reg_wr = 1'b0;
    rd_reg(3, d, p); check("R12 rx write no status change", d, 32'h0B);
    wr_reg(2, 32'h0000_01A5); rd_reg(2, d, p); check("R13 enable readback", d, 32'hA5);
    rd_reg(5, d, p); check("R13 unmapped reads zero", d, 32'h0);
    wr_reg(2, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_levels();
    t_overflow();
    t_done();
    t_irq();
    t_rxread();
    t_misc();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule